// File: doc/BRIEF.md
# Hall Commutation and Decay Logic

This block turns three Hall sensor levels, spaced 120 electrical degrees apart, together with a rotation direction input, into six gate enables for a three-phase bridge: one high-side and one low-side enable per phase. In each valid rotor sector it drives one phase high and one phase low. The third phase is left floating. The Hall lines pass through a two-flop synchroniser before they are decoded. A one-cycle strobe marks each change of the accepted sector.

The block also sets the bridge state during current-decay periods. A decay period begins when the speed input goes low or when the current chopper reports recirculation. In the slow mode, both low-side switches of the active pair conduct. In the fast mode, only the low side of the phase whose high side was driving is switched on. This gives synchronous rectification on the low side only.

A supervisor can request coast (all gates off) or brake (all low sides on). A Hall code of 000 or 111 raises an invalid flag and coasts the bridge. Control is held in a four-state machine:
- `ST_COAST`, `ST_BRAKE`, `ST_DRIVE` and `ST_DECAY` are the four states.
- Every clock, the machine takes the **coast-entry** transition when a coast request or an invalid code is present.
- Otherwise it takes the **brake-entry** transition when a brake request is present.
- Otherwise it takes the **drive-entry** transition when the speed input is high with no recirculation.
- In all remaining cases it takes the **decay-entry** transition.

Dead-time insertion happens in a separate block downstream.

Top module: `bldc_comm_logic`

## Requirements
- R1: A change on `hall_in` reaches the gate outputs on the third rising clock edge after it is first sampled (two synchroniser flops plus one sector register), and not earlier.
- R2: With `dir`=1 and a run condition (`pwm_in`=1, `chop_recirc`=0, no requests), the high/low phase pair for each Hall code `hall_in[2:0]` is as follows, with phase A on bit 0, B on bit 1 and C on bit 2 of `gh`/`gl`:
  - 001 drives A high and B low.
  - 010 drives C high and A low.
  - 011 drives C high and B low.
  - 100 drives B high and C low.
  - 101 drives A high and C low.
  - 110 drives B high and A low.
- R3: With `dir`=0, each code drives the same two phases as in R2 with the high and low roles exchanged.
- R4: Codes 000 and 111 set `hall_invalid` and turn all six gates off. The last valid sector is retained while the code is invalid.
- R5: `comm_strobe` is high for exactly one clock when an accepted valid code differs from the previously accepted one. Returning to the retained code after an invalid code produces no strobe.
- R6: During a decay period with `decay_slow`=1, all high sides are off and the low sides of both phases of the active pair are on.
- R7: During a decay period with `decay_slow`=0, all high sides are off and only the low side of the phase that was driven high is on.
- R8: With `force_brake`=1 (and no coast request and a valid code), all three low sides are on and all high sides are off, one clock after the request is sampled.
- R9: `force_coast` turns every gate off one clock after it is sampled, and it overrides `force_brake`. An invalid code also overrides `force_brake`.
- R10: The high-side and low-side enables of the same phase are never high together.
- R11: While reset is asserted, all gates are off and `comm_strobe` and `hall_invalid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hall_in | input | 3 | Raw Hall levels, bit 2 first sensor, bit 0 third |
| dir | input | 1 | Rotation direction |
| decay_slow | input | 1 | 1 selects slow decay, 0 fast decay |
| pwm_in | input | 1 | Speed control; 0 starts a decay period |
| chop_recirc | input | 1 | Chopper off-time flag; 1 starts a decay period |
| force_coast | input | 1 | Supervisor coast request |
| force_brake | input | 1 | Supervisor brake request |
| gh | output | 3 | High-side gate enables, bit 0 = phase A |
| gl | output | 3 | Low-side gate enables, bit 0 = phase A |
| comm_strobe | output | 1 | One-clock pulse on a new valid sector |
| hall_invalid | output | 1 | Current synchronised Hall code is 000 or 111 |

## Verification
The bound checker enforces the following on every cycle:
- No phase has both enables high.
- At most one high side is on.
- An invalid flag always comes with all gates off.
- A strobe never coincides with an invalid flag.
- A coast or brake request produces its gate pattern one clock later.

Only the directed scenarios can show the rest:
- The full sector tables in both directions.
- The exact three-edge Hall latency.
- The absence of a strobe when the retained sector comes back after an invalid code.
- The distinction between the two decay patterns.

// File: rtl/bldc_comm_pkg.sv
package bldc_comm_pkg;
    localparam int PHASES = 3;

    typedef enum logic [1:0] {
        ST_COAST,
        ST_BRAKE,
        ST_DRIVE,
        ST_DECAY
    } gate_state_e;

    function automatic logic code_is_bad(input logic [PHASES-1:0] code);
        return (code == '0) || (code == '1);
    endfunction
endpackage

// File: rtl/hall_sync.sv
module hall_sync
    import bldc_comm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PHASES-1:0] hall_in,
    output logic [PHASES-1:0] code_q,
    output logic              code_bad,
    output logic              bad_q,
    output logic              strobe_q
);
    logic [PHASES-1:0] stg [SYNC_STAGES];
    logic [PHASES-1:0] synced;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[i] <= '0;
                    else        stg[i] <= hall_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[i] <= '0;
                    else        stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign synced   = stg[SYNC_STAGES-1];
    assign code_bad = code_is_bad(synced);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q   <= '0;
            bad_q    <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            bad_q    <= code_bad;
            strobe_q <= !code_bad && (synced != code_q);
            if (!code_bad) code_q <= synced;
        end
    end
endmodule

// File: rtl/sector_decode.sv
module sector_decode
    import bldc_comm_pkg::*;
(
    input  logic [PHASES-1:0] code,
    output logic [PHASES-1:0] hi_oh,
    output logic [PHASES-1:0] lo_oh
);
    // Forward-direction sector table; bit 0 = phase A.
    always_comb begin
        hi_oh = '0;
        lo_oh = '0;
        case (code)
            3'b101: begin hi_oh = 3'b001; lo_oh = 3'b100; end
            3'b100: begin hi_oh = 3'b010; lo_oh = 3'b100; end
            3'b110: begin hi_oh = 3'b010; lo_oh = 3'b001; end
            3'b010: begin hi_oh = 3'b100; lo_oh = 3'b001; end
            3'b011: begin hi_oh = 3'b100; lo_oh = 3'b010; end
            3'b001: begin hi_oh = 3'b001; lo_oh = 3'b010; end
            default: begin hi_oh = '0; lo_oh = '0; end
        endcase
    end
endmodule

// File: rtl/gate_fsm.sv
module gate_fsm
    import bldc_comm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_bad,
    input  logic              dir,
    input  logic              decay_slow,
    input  logic              pwm_in,
    input  logic              chop_recirc,
    input  logic              force_coast,
    input  logic              force_brake,
    input  logic [PHASES-1:0] hi_oh,
    input  logic [PHASES-1:0] lo_oh,
    output logic [PHASES-1:0] gh,
    output logic [PHASES-1:0] gl
);
    gate_state_e state;
    logic        dir_r;
    logic        slow_r;
    logic [PHASES-1:0] hi_sel, lo_sel;

    // State register with its transitions.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_COAST;
            dir_r  <= 1'b1;
            slow_r <= 1'b0;
        end else begin
            dir_r  <= dir;
            slow_r <= decay_slow;
            if (force_coast || code_bad)       state <= ST_COAST;
            else if (force_brake)              state <= ST_BRAKE;
            else if (pwm_in && !chop_recirc)   state <= ST_DRIVE;
            else                               state <= ST_DECAY;
        end
    end

    assign hi_sel = dir_r ? hi_oh : lo_oh;
    assign lo_sel = dir_r ? lo_oh : hi_oh;

    // Output decode per state.
    always_comb begin
        gh = '0;
        gl = '0;
        unique case (state)
            ST_COAST: begin gh = '0;     gl = '0;     end
            ST_BRAKE: begin gh = '0;     gl = '1;     end
            ST_DRIVE: begin gh = hi_sel; gl = lo_sel; end
            ST_DECAY: begin
                gh = '0;
                gl = slow_r ? (hi_sel | lo_sel) : hi_sel;
            end
        endcase
    end
endmodule

// File: rtl/bldc_comm_logic.sv
module bldc_comm_logic
    import bldc_comm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hall_in,
    input  logic       dir,
    input  logic       decay_slow,
    input  logic       pwm_in,
    input  logic       chop_recirc,
    input  logic       force_coast,
    input  logic       force_brake,
    output logic [2:0] gh,
    output logic [2:0] gl,
    output logic       comm_strobe,
    output logic       hall_invalid
);
    logic [PHASES-1:0] code_q, hi_oh, lo_oh;
    logic              code_bad;

    hall_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .hall_in  (hall_in),
        .code_q   (code_q),
        .code_bad (code_bad),
        .bad_q    (hall_invalid),
        .strobe_q (comm_strobe)
    );

    sector_decode u_dec (
        .code  (code_q),
        .hi_oh (hi_oh),
        .lo_oh (lo_oh)
    );

    gate_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .code_bad    (code_bad),
        .dir         (dir),
        .decay_slow  (decay_slow),
        .pwm_in      (pwm_in),
        .chop_recirc (chop_recirc),
        .force_coast (force_coast),
        .force_brake (force_brake),
        .hi_oh       (hi_oh),
        .lo_oh       (lo_oh),
        .gh          (gh),
        .gl          (gl)
    );
endmodule

// File: rtl/bldc_comm_checker.sv
module bldc_comm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       force_coast,
    input logic       force_brake,
    input logic [2:0] gh,
    input logic [2:0] gl,
    input logic       comm_strobe,
    input logic       hall_invalid
);
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_no_phase_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (gh & gl) == 3'b000);

    assert_single_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gh));

    assert_invalid_coasts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hall_invalid |-> (gh == 3'b000 && gl == 3'b000));

    assert_strobe_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        comm_strobe |-> !hall_invalid);

    assert_coast_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(force_coast)) |-> (gh == 3'b000 && gl == 3'b000));

    assert_brake_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(force_brake && !force_coast) && !hall_invalid)
            |-> (gh == 3'b000 && gl == 3'b111));
endmodule

bind bldc_comm_logic bldc_comm_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .force_coast  (force_coast),
    .force_brake  (force_brake),
    .gh           (gh),
    .gl           (gl),
    .comm_strobe  (comm_strobe),
    .hall_invalid (hall_invalid)
);

// File: tb/tb_bldc_comm_logic.sv
module tb_bldc_comm_logic;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] hall_in;
    logic       dir, decay_slow, pwm_in, chop_recirc, force_coast, force_brake;
    logic [2:0] gh, gl;
    logic       comm_strobe, hall_invalid;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bldc_comm_logic dut (
        .clk(clk), .rst_n(rst_n), .hall_in(hall_in), .dir(dir),
        .decay_slow(decay_slow), .pwm_in(pwm_in), .chop_recirc(chop_recirc),
        .force_coast(force_coast), .force_brake(force_brake),
        .gh(gh), .gl(gl), .comm_strobe(comm_strobe), .hall_invalid(hall_invalid)
    );

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic chk_gates(input string req, input logic [2:0] eh, input logic [2:0] el);
        chk({gh, gl} == {eh, el}, req, {2'b00, gh, gl}, {2'b00, eh, el});
    endtask

    // Forward-direction pair for a code: {high phase one-hot, low phase one-hot}.
    function automatic logic [5:0] fwd_pair(input logic [2:0] c);
        case (c)
            3'b001: return {3'b001, 3'b010};
            3'b010: return {3'b100, 3'b001};
            3'b011: return {3'b100, 3'b010};
            3'b100: return {3'b010, 3'b100};
            3'b101: return {3'b001, 3'b100};
            3'b110: return {3'b010, 3'b001};
            default: return 6'b0;
        endcase
    endfunction

    task automatic settle();
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic set_hall(input logic [2:0] c);
        @(negedge clk);
        hall_in = c;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; hall_in = 3'b101; dir = 1'b1; decay_slow = 1'b0;
        pwm_in = 1'b1; chop_recirc = 1'b0; force_coast = 1'b0; force_brake = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk_gates("R11 gates in reset", 3'b000, 3'b000);
        chk({comm_strobe, hall_invalid} == 2'b00, "R11 flags in reset",
            {6'b0, comm_strobe, hall_invalid}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        settle();
    endtask

    task automatic t_table(input logic d);
        logic [2:0] seq [6] = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};
        @(negedge clk);
        dir = d;
        for (int i = 0; i < 6; i++) begin
            logic [5:0] p;
            set_hall(seq[i]);
            settle();
            p = fwd_pair(seq[i]);
            if (d) chk_gates("R2 forward sector", p[5:3], p[2:0]);
            else   chk_gates("R3 reverse sector", p[2:0], p[5:3]);
        end
    endtask

    task automatic t_latency_strobe();
        @(negedge clk); dir = 1'b1;
        set_hall(3'b101);
        settle();
        set_hall(3'b100);
        repeat (2) @(posedge clk);
        #1;
        chk_gates("R1 gates unchanged after two edges", 3'b001, 3'b100);
        chk(comm_strobe == 1'b0, "R5 no early strobe", {7'b0, comm_strobe}, 8'h00);
        @(posedge clk); #1;
        chk_gates("R1 gates updated on third edge", 3'b010, 3'b100);
        chk(comm_strobe == 1'b1, "R5 strobe on new sector", {7'b0, comm_strobe}, 8'h01);
        @(posedge clk); #1;
        chk(comm_strobe == 1'b0, "R5 strobe lasts one clock", {7'b0, comm_strobe}, 8'h00);
    endtask

    task automatic t_invalid(input logic [2:0] bad);
        set_hall(3'b101);
        settle();
        set_hall(bad);
        settle();
        chk(hall_invalid == 1'b1, "R4 invalid flag", {7'b0, hall_invalid}, 8'h01);
        chk_gates("R4 invalid coasts", 3'b000, 3'b000);
        set_hall(3'b101);
        repeat (3) @(posedge clk);
        #1;
        chk(comm_strobe == 1'b0, "R5 R4 no strobe on retained sector", {7'b0, comm_strobe}, 8'h00);
        chk(hall_invalid == 1'b0, "R4 flag clears", {7'b0, hall_invalid}, 8'h00);
        chk_gates("R4 drive resumes", 3'b001, 3'b100);
    endtask

    task automatic t_decay();
        set_hall(3'b110);
        settle();
        @(negedge clk); decay_slow = 1'b1; pwm_in = 1'b0;
        @(posedge clk); #1;
        chk_gates("R6 slow decay on pwm low", 3'b000, 3'b011);
        @(negedge clk); decay_slow = 1'b0;
        @(posedge clk); #1;
        chk_gates("R7 fast decay on pwm low", 3'b000, 3'b010);
        @(negedge clk); pwm_in = 1'b1; chop_recirc = 1'b1;
        @(posedge clk); #1;
        chk_gates("R7 fast decay on recirculation", 3'b000, 3'b010);
        @(negedge clk); dir = 1'b0; decay_slow = 1'b1;
        @(posedge clk); #1;
        chk_gates("R6 slow decay reverse", 3'b000, 3'b011);
        @(negedge clk); decay_slow = 1'b0;
        @(posedge clk); #1;
        chk_gates("R7 fast decay reverse", 3'b000, 3'b001);
        @(negedge clk); chop_recirc = 1'b0; dir = 1'b1;
        @(posedge clk); #1;
        chk_gates("R2 drive after decay", 3'b010, 3'b001);
    endtask

    task automatic t_requests();
        @(negedge clk); force_brake = 1'b1;
        @(posedge clk); #1;
        chk_gates("R8 brake", 3'b000, 3'b111);
        @(negedge clk); force_coast = 1'b1;
        @(posedge clk); #1;
        chk_gates("R9 coast overrides brake", 3'b000, 3'b000);
        @(negedge clk); force_coast = 1'b0;
        @(posedge clk); #1;
        chk_gates("R8 brake after coast release", 3'b000, 3'b111);
        set_hall(3'b111);
        settle();
        chk_gates("R9 invalid overrides brake", 3'b000, 3'b000);
        set_hall(3'b110);
        @(negedge clk); force_brake = 1'b0;
        settle();
        chk_gates("R10 run again", 3'b010, 3'b001);
    endtask

    initial begin
        t_reset();
        t_table(1'b1);
        t_table(1'b0);
        t_latency_strobe();
        t_invalid(3'b000);
        t_invalid(3'b111);
        t_decay();
        t_requests();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule